// File: doc/BRIEF.md
# Serial Flash Status Register and Write-Protection Guard

This block holds the status byte of a serial NOR flash and decides whether each modifying command may proceed. A command decoder elsewhere delivers one-cycle strobes: set or clear the write-enable latch, write the status byte, program, erase a sector, erase a block, erase the whole chip, and enter or leave the one-time-programmable (OTP) sector mode. For every status write, program or erase, the block answers one cycle later with an accept or a reject pulse. It also exposes the status byte that a status-read path would shift out.

Protection comes from three sources. A three-bit software code shields a range of blocks at the top of the array. A protect bit, together with a low write-protect pin, freezes the status byte. In OTP mode a lock bit takes over bit 7 of the status byte; once set, it shields the OTP sector for good. The protect bit, the protect code and the lock bit stand in for non-volatile cells. A soft reset leaves them alone, and only the power-on clear resets them. Program and erase timing is not modelled here: a completion strobe from outside ends each busy cycle.

Top module: `flash_status_guard`

## Requirements
- R1: The status byte holds, from bit 7 down to bit 0: bit 7 is the protect bit (or the OTP lock while in OTP mode); bits 6:5 are the interface mode; bits 4:2 are the protect code; bit 1 is the write-enable latch; bit 0 is the busy flag.
- R2: Power-on clear sets the whole status byte to 0 and leaves OTP mode. A soft reset clears the busy flag, the write-enable latch, the interface mode and OTP mode, and keeps the protect bit, the protect code and the OTP lock.
- R3: While the block is idle, the write-enable strobe sets the latch and the write-disable strobe clears it.
- R4: With the write-enable latch at 0, any status write, program or erase is rejected and the status byte does not change.
- R5: An accepted command sets the busy flag on the next cycle. The completion strobe then clears both the busy flag and the write-enable latch.
- R6: While busy, every modifying command is rejected and the status byte does not change.
- R7: A protect code n from 1 to 7 shields the top min(2^(n-1), NUM_BLOCKS) blocks. A program, sector erase or block erase whose target block falls in that range is rejected. A target outside it is accepted.
- R8: Chip erase is accepted only when the protect code is 000, and it is always rejected in OTP mode.
- R9: With the protect bit at 1 and wp_n low, outside OTP mode, a status write is rejected. With wp_n high, the same write is accepted.
- R10: An accepted status write outside OTP mode loads data bit 7 into the protect bit and data bits 4:2 into the protect code. It loads data bits 6:5 into the interface mode only when they are 00 or 01, and it ignores data bits 1:0.
- R11: In OTP mode, bit 7 of the status byte shows the lock. An accepted status write ignores its data and sets the lock to 1, and no command clears the lock afterwards.
- R12: In OTP mode, program and sector erase target the OTP sector. They are accepted when the lock is 0, whatever the protect code, and rejected when the lock is 1. Block erase is rejected in OTP mode.
- R13: Each status write, program or erase strobe yields exactly one one-cycle pulse, on accept or on reject, in the cycle after the strobe. The two outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous soft reset, active low |
| por_n | input | 1 | Asynchronous power-on clear of the non-volatile bits, active low |
| cmd_wren | input | 1 | Set write-enable latch |
| cmd_wrdi | input | 1 | Clear write-enable latch |
| cmd_wrsr | input | 1 | Write status byte |
| wrsr_data | input | 8 | Data byte for status write |
| cmd_prog | input | 1 | Page program |
| cmd_sect_erase | input | 1 | Sector erase |
| cmd_blk_erase | input | 1 | Block erase |
| cmd_chip_erase | input | 1 | Chip erase |
| cmd_otp_enter | input | 1 | Enter OTP mode |
| cmd_otp_exit | input | 1 | Leave OTP mode |
| tgt_blk | input | BLK_W | Target block index of a program or erase |
| wp_n | input | 1 | Write-protect pin, active low |
| done | input | 1 | Busy-cycle completion strobe |
| status | output | 8 | Status byte |
| accept | output | 1 | Modifying command accepted (registered) |
| reject | output | 1 | Modifying command rejected (registered) |

## Verification
The accept decision is tried with a program just below the protected range and with erases inside it. This separates the range boundary from a blanket block on any nonzero code. Chip erase is tried with the protect code nonzero and then zero. The same status write is sent with the pin low and then high, which isolates the hardware lock from the latch. In OTP mode a program to a block the protect code would shield is accepted before locking and rejected after it. Leaving and re-entering the mode then shows that bit 7 switches between the protect bit and the lock.

// File: rtl/flash_status_guard.sv
module flash_status_guard #(
  parameter int NUM_BLOCKS = 32,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_n,
  input  logic             cmd_wren,
  input  logic             cmd_wrdi,
  input  logic             cmd_wrsr,
  input  logic [7:0]       wrsr_data,
  input  logic             cmd_prog,
  input  logic             cmd_sect_erase,
  input  logic             cmd_blk_erase,
  input  logic             cmd_chip_erase,
  input  logic             cmd_otp_enter,
  input  logic             cmd_otp_exit,
  input  logic [BLK_W-1:0] tgt_blk,
  input  logic             wp_n,
  input  logic             done,
  output logic [7:0]       status,
  output logic             accept,
  output logic             reject
);

  logic       srp_q, otp_lock_q, wel_q, wip_q, otp_mode_q, acc_q, rej_q;
  logic [2:0] bp_q;
  logic [1:0] mode_q;
  logic       any_mod, hw_lock, blk_prot, ok, go;

  function automatic logic in_shield(input logic [2:0] code, input logic [BLK_W-1:0] blk);
    int span;
    if (code == 3'd0) return 1'b0;
    span = (int'(code) - 1 >= BLK_W) ? NUM_BLOCKS : (1 << (int'(code) - 1));
    if (span > NUM_BLOCKS) span = NUM_BLOCKS;
    return int'(blk) >= NUM_BLOCKS - span;
  endfunction

  assign any_mod  = cmd_wrsr | cmd_prog | cmd_sect_erase | cmd_blk_erase | cmd_chip_erase;
  assign hw_lock  = srp_q & ~wp_n & ~otp_mode_q;
  assign blk_prot = in_shield(bp_q, tgt_blk);

  always_comb begin
    ok = 1'b0;
    if (cmd_wrsr)                       ok = ~hw_lock;
    else if (cmd_prog | cmd_sect_erase) ok = otp_mode_q ? ~otp_lock_q : ~blk_prot;
    else if (cmd_blk_erase)             ok = ~otp_mode_q & ~blk_prot;
    else if (cmd_chip_erase)            ok = ~otp_mode_q & (bp_q == 3'd0);
  end

  assign go = any_mod & wel_q & ~wip_q & ok;

  always_ff @(posedge clk or negedge rst_n or negedge por_n) begin
    if (!rst_n || !por_n) begin
      wel_q      <= 1'b0;
      wip_q      <= 1'b0;
      mode_q     <= 2'b00;
      otp_mode_q <= 1'b0;
      acc_q      <= 1'b0;
      rej_q      <= 1'b0;
    end else begin
      acc_q <= go;
      rej_q <= any_mod & ~go;
      if (wip_q) begin
        if (done) begin
          wip_q <= 1'b0;
          wel_q <= 1'b0;
        end
      end else if (go) begin
        wip_q <= 1'b1;
        if (cmd_wrsr && !otp_mode_q && !wrsr_data[6]) mode_q <= wrsr_data[6:5];
      end else if (!any_mod) begin
        if (cmd_wren)      wel_q <= 1'b1;
        else if (cmd_wrdi) wel_q <= 1'b0;
        if (cmd_otp_enter)     otp_mode_q <= 1'b1;
        else if (cmd_otp_exit) otp_mode_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      srp_q      <= 1'b0;
      bp_q       <= 3'd0;
      otp_lock_q <= 1'b0;
    end else if (go && cmd_wrsr) begin
      if (otp_mode_q) otp_lock_q <= 1'b1;
      else begin
        srp_q <= wrsr_data[7];
        bp_q  <= wrsr_data[4:2];
      end
    end
  end

  assign status = {otp_mode_q ? otp_lock_q : srp_q, mode_q, bp_q, wel_q, wip_q};
  assign accept = acc_q;
  assign reject = rej_q;

  a_r13_one_outcome: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !(accept && reject));
  a_r13_answer: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    any_mod |=> (accept || reject));
  a_r6_busy_reject: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (status[0] && any_mod) |=> reject);
  a_r4_no_latch_reject: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (!status[1] && any_mod) |=> reject);
  a_r5_done_clears: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (status[0] && done) |=> (!status[0] && !status[1]));
  a_r8_chip_guard: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (cmd_chip_erase && status[4:2] != 3'd0) |=> reject);
  a_r9_hw_lock: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (cmd_wrsr && !wp_n && srp_q && !otp_mode_q) |=> reject);
  a_r11_lock_sticky: assert property (@(posedge clk) disable iff (!por_n)
    otp_lock_q |=> otp_lock_q);

endmodule

// File: tb/test_flash_status_guard.sv
module test_flash_status_guard;
  localparam int PERIOD = 10;
  localparam int NB = 32;
  localparam int BW = $clog2(NB);

  localparam int C_WREN = 0, C_WRDI = 1, C_WRSR = 2, C_PROG = 3, C_SE = 4,
                 C_BE = 5, C_CE = 6, C_OTPIN = 7, C_OTPOUT = 8, C_DONE = 9;

  logic clk = 1'b0, rst_n = 1'b0, por_n = 1'b0;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_prog = 0, cmd_sect_erase = 0;
  logic cmd_blk_erase = 0, cmd_chip_erase = 0, cmd_otp_enter = 0, cmd_otp_exit = 0;
  logic [7:0] wrsr_data = 8'h00;
  logic [BW-1:0] tgt_blk = '0;
  logic wp_n = 1'b1, done = 1'b0;
  logic [7:0] status;
  logic accept, reject;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  flash_status_guard #(.NUM_BLOCKS(NB)) i_flash_status_guard (
    .clk(clk), .rst_n(rst_n), .por_n(por_n),
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data),
    .cmd_prog(cmd_prog), .cmd_sect_erase(cmd_sect_erase), .cmd_blk_erase(cmd_blk_erase),
    .cmd_chip_erase(cmd_chip_erase), .cmd_otp_enter(cmd_otp_enter), .cmd_otp_exit(cmd_otp_exit),
    .tgt_blk(tgt_blk), .wp_n(wp_n), .done(done),
    .status(status), .accept(accept), .reject(reject));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input int c, input logic [7:0] d, input int blk,
                      input logic ea, input logic er, input logic [7:0] es, input string req);
    @(negedge clk);
    wrsr_data = d;
    tgt_blk = BW'(blk);
    cmd_wren = (c == C_WREN);  cmd_wrdi = (c == C_WRDI);  cmd_wrsr = (c == C_WRSR);
    cmd_prog = (c == C_PROG);  cmd_sect_erase = (c == C_SE); cmd_blk_erase = (c == C_BE);
    cmd_chip_erase = (c == C_CE); cmd_otp_enter = (c == C_OTPIN);
    cmd_otp_exit = (c == C_OTPOUT); done = (c == C_DONE);
    @(negedge clk);
    {cmd_wren, cmd_wrdi, cmd_wrsr, cmd_prog, cmd_sect_erase, cmd_blk_erase,
     cmd_chip_erase, cmd_otp_enter, cmd_otp_exit, done} = '0;
    check({req, " accept"}, accept, ea);
    check({req, " reject"}, reject, er);
    check({req, " status"}, status, es);
  endtask

  task automatic t_power_on;
    @(negedge clk);
    check("R2 power-on status", status, 8'h00);
    check("R13 idle accept", accept, 1'b0);
    check("R13 idle reject", reject, 1'b0);
  endtask

  task automatic t_latch;
    send(C_WREN, 0, 0, 0, 0, 8'h02, "R3 wren");
    send(C_WRDI, 0, 0, 0, 0, 8'h00, "R3 wrdi");
    send(C_PROG, 0, 0, 0, 1, 8'h00, "R4 program without latch");
    send(C_WRSR, 8'hFF, 0, 0, 1, 8'h00, "R4 status write without latch");
  endtask

  task automatic t_status_write;
    send(C_WREN, 0, 0, 0, 0, 8'h02, "R3 wren");
    send(C_WRSR, 8'hED, 0, 1, 0, 8'h8F, "R10 write, mode 11 kept at 00, R1 layout");
    send(C_PROG, 0, 0, 0, 1, 8'h8F, "R6 program while busy");
    send(C_WREN, 0, 0, 0, 0, 8'h8F, "R6 wren while busy");
    send(C_DONE, 0, 0, 0, 0, 8'h8C, "R5 completion clears busy and latch");
    @(negedge clk);
    check("R13 pulse lasts one cycle", accept, 1'b0);
  endtask

  task automatic t_block_shield;
    send(C_WREN, 0, 0, 0, 0, 8'h8E, "R3 wren");
    send(C_PROG, 0, 27, 1, 0, 8'h8F, "R7 program below shield");
    send(C_DONE, 0, 0, 0, 0, 8'h8C, "R5 completion");
    send(C_WREN, 0, 0, 0, 0, 8'h8E, "R3 wren");
    send(C_SE, 0, 28, 0, 1, 8'h8E, "R7 sector erase at shield edge");
    send(C_BE, 0, 31, 0, 1, 8'h8E, "R7 block erase top block");
    send(C_CE, 0, 0, 0, 1, 8'h8E, "R8 chip erase with code 011");
  endtask

  task automatic t_hw_lock;
    wp_n = 1'b0;
    send(C_WRSR, 8'h00, 0, 0, 1, 8'h8E, "R9 write with pin low");
    wp_n = 1'b1;
    send(C_WRSR, 8'h20, 0, 1, 0, 8'h23, "R9 write with pin high, R10 mode 01");
    send(C_DONE, 0, 0, 0, 0, 8'h20, "R5 completion");
    send(C_WREN, 0, 0, 0, 0, 8'h22, "R3 wren");
    send(C_CE, 0, 0, 1, 0, 8'h23, "R8 chip erase with code 000");
    send(C_DONE, 0, 0, 0, 0, 8'h20, "R5 completion");
  endtask

  task automatic t_soft_reset;
    send(C_WREN, 0, 0, 0, 0, 8'h22, "R3 wren");
    send(C_WRSR, 8'hA8, 0, 1, 0, 8'hAB, "R10 write protect bit and code 010");
    send(C_DONE, 0, 0, 0, 0, 8'hA8, "R5 completion");
    send(C_WREN, 0, 0, 0, 0, 8'hAA, "R3 wren");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R2 soft reset keeps protect bits", status, 8'h88);
    send(C_WREN, 0, 0, 0, 0, 8'h8A, "R3 wren");
    send(C_WRSR, 8'h08, 0, 1, 0, 8'h0B, "R10 clear protect bit");
    send(C_DONE, 0, 0, 0, 0, 8'h08, "R5 completion");
  endtask

  task automatic t_otp;
    send(C_OTPIN, 0, 0, 0, 0, 8'h08, "R11 enter, lock shows 0");
    send(C_WREN, 0, 0, 0, 0, 8'h0A, "R3 wren");
    send(C_PROG, 0, 31, 1, 0, 8'h0B, "R12 program unlocked OTP despite code");
    send(C_DONE, 0, 0, 0, 0, 8'h08, "R5 completion");
    send(C_WREN, 0, 0, 0, 0, 8'h0A, "R3 wren");
    send(C_BE, 0, 0, 0, 1, 8'h0A, "R12 block erase in OTP mode");
    send(C_CE, 0, 0, 0, 1, 8'h0A, "R8 chip erase in OTP mode");
    send(C_WRSR, 8'h00, 0, 1, 0, 8'h8B, "R11 status write sets lock");
    send(C_DONE, 0, 0, 0, 0, 8'h88, "R5 completion");
    send(C_WREN, 0, 0, 0, 0, 8'h8A, "R3 wren");
    send(C_SE, 0, 0, 0, 1, 8'h8A, "R12 sector erase locked OTP");
    send(C_OTPOUT, 0, 0, 0, 0, 8'h0A, "R11 exit shows protect bit");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    send(C_OTPIN, 0, 0, 0, 0, 8'h88, "R11 lock survives reset");
    send(C_WREN, 0, 0, 0, 0, 8'h8A, "R3 wren");
    send(C_WRSR, 8'h00, 0, 1, 0, 8'h8B, "R11 lock stays set");
    send(C_DONE, 0, 0, 0, 0, 8'h88, "R5 completion");
  endtask

  task automatic t_power_clear;
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    @(negedge clk);
    check("R2 power-on clear", status, 8'h00);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    rst_n = 1'b1;
    t_power_on();
    t_latch();
    t_status_write();
    t_block_shield();
    t_hw_lock();
    t_soft_reset();
    t_otp();
    t_power_clear();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule